// File: doc/BRIEF.md
# Embedded Core Test Collar

This block surrounds an embedded core and gives a tester access to every core terminal through a serial scan path. A two-bit instruction register selects one of four behaviours. The instruction is shifted in serially and only takes effect on a commit pulse. In functional mode the host and core are wired straight through. In external test, the collar drives the host side and samples what the host presents, which lets the surrounding interconnect be checked. In internal test, the collar forces the core inputs and samples the core outputs, which lets the core logic be checked. In bypass, a one-bit register shortens the serial path.

Every terminal owns a cell with two storage elements. The first is a scan flop that captures or shifts. The second is a hold register that supplies the forced value. Because the hold register changes only on an update pulse, the driven values stay still while new data is shifted in. The data interfaces here are plain bit-level test signals with no back-pressure: each control pin acts in the cycle it is sampled high.

Top module: `core_collar`

## Requirements
- R1: A low `rst_n` forces functional mode (code 00). It also clears every scan flop, every hold register and the bypass bit.
- R2: In functional mode, `core_in` equals `host_in` and `host_out` equals `core_out`. Chain shifting in this mode has no effect on these outputs.
- R3: Instruction shifting works as follows:
  - While `ir_shift` is high, `wsi` enters the instruction register at bit 1 and the register moves toward bit 0, so the first bit sent becomes bit 0.
  - During that time, `wso` shows bit 0 of the instruction register.
  - The codes are 00 functional, 01 external test, 10 internal test and 11 bypass.
  - The active mode changes only in a cycle where `ir_update` is high.
- R4: Chain order and shifting:
  - The serial chain runs from `wsi` through input cells 0 to N_IN-1, then through output cells 0 to N_OUT-1, to `wso`.
  - `wso` is the last output cell's scan flop.
  - Each `shift_en` cycle outside bypass moves the chain one place.
- R5: In external test, `capture_en` loads `host_in` into the input-cell scan flops, and the output-cell scan flops keep their contents.
- R6: In external test, `host_out` is driven from the output-cell hold registers, and `core_in` follows `host_in`.
- R7: In internal test, `core_in` is driven from the input-cell hold registers, and `host_out` follows `core_out`.
- R8: In internal test, `capture_en` loads `core_out` into the output-cell scan flops, and the input-cell scan flops keep their contents.
- R9: Hold registers copy the scan flops only in an `update_en` cycle. Shifting or capturing without `update_en` leaves the driven values unchanged.
- R10: Bypass mode works as follows:
  - `wso` is a one-bit register loaded from `wsi` on `shift_en`, and cleared on `capture_en`.
  - The data paths behave as in functional mode.
  - The wrapper chain does not move.
- R11: When `capture_en` and `shift_en` are both high in one cycle, capture wins. When `update_en` and `shift_en` are both high in one cycle, the hold registers take the contents from before that shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test and functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_in | input | N_IN | Values the host presents to the core inputs |
| core_in | output | N_IN | Values delivered to the core inputs |
| core_out | input | N_OUT | Values produced by the core outputs |
| host_out | output | N_OUT | Values delivered to the host |
| wsi | input | 1 | Serial data in, shared by instruction and data paths |
| wso | output | 1 | Serial data out |
| capture_en | input | 1 | Parallel capture into the selected scan flops |
| shift_en | input | 1 | Shift the chain or the bypass bit one place |
| update_en | input | 1 | Copy scan flops into hold registers |
| ir_shift | input | 1 | Shift the instruction register |
| ir_update | input | 1 | Commit the shifted instruction as the active mode |

## Verification
Shifting and updating can land in the same cycle. The bench provokes this by raising `shift_en` and `update_en` together after a known pattern has been loaded. It then judges the hold registers through `host_out` in external test, which must show the pattern from before the shift. Capture and shift are also raised together. The following scan-out must show the captured host values rather than the shifted-in bit.

// File: rtl/collar_pkg.sv
`timescale 1ns/1ps
package collar_pkg;
  localparam int IR_W = 2;

  typedef enum logic [IR_W-1:0] {
    MODE_FUNC = 2'b00,
    MODE_EXT  = 2'b01,
    MODE_INT  = 2'b10,
    MODE_BYP  = 2'b11
  } collar_mode_e;
endpackage

// File: rtl/collar_cell.sv
`timescale 1ns/1ps
module collar_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_en,
  input  logic shf_en,
  input  logic upd_en,
  input  logic par_in,
  input  logic ser_in,
  output logic ser_out,
  output logic hold_out
);
  logic scan_q;
  logic hold_q;

  // Capture outranks shift; the hold register samples the pre-edge scan value.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      if (cap_en)      scan_q <= par_in;
      else if (shf_en) scan_q <= ser_in;
      if (upd_en)      hold_q <= scan_q;
    end
  end

  assign ser_out  = scan_q;
  assign hold_out = hold_q;
endmodule

// File: rtl/collar_ir.sv
`timescale 1ns/1ps
module collar_ir
  import collar_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ser_in,
  input  logic         shf_en,
  input  logic         commit,
  output logic         ser_out,
  output collar_mode_e mode
);
  logic [IR_W-1:0] sr_q;
  collar_mode_e    mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      mode_q <= MODE_FUNC;
    end else begin
      if (shf_en) sr_q   <= {ser_in, sr_q[IR_W-1:1]};
      if (commit) mode_q <= collar_mode_e'(sr_q);
    end
  end

  assign ser_out = sr_q[0];
  assign mode    = mode_q;
endmodule

// File: rtl/collar_byp.sv
`timescale 1ns/1ps
module collar_byp (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_in,
  input  logic shf_en,
  input  logic cap_en,
  output logic ser_out
);
  logic bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bit_q <= 1'b0;
    else if (cap_en) bit_q <= 1'b0;
    else if (shf_en) bit_q <= ser_in;
  end

  assign ser_out = bit_q;
endmodule

// File: rtl/core_collar.sv
`timescale 1ns/1ps
module core_collar
  import collar_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int N_OUT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IN-1:0]  host_in,
  output logic [N_IN-1:0]  core_in,
  input  logic [N_OUT-1:0] core_out,
  output logic [N_OUT-1:0] host_out,
  input  logic             wsi,
  output logic             wso,
  input  logic             capture_en,
  input  logic             shift_en,
  input  logic             update_en,
  input  logic             ir_shift,
  input  logic             ir_update
);
  localparam int N_CELL = N_IN + N_OUT;

  collar_mode_e      mode_q;
  logic              ir_so;
  logic              byp_so;
  logic [N_CELL-1:0] scan_q;
  logic [N_CELL-1:0] hold_q;
  logic              cap_in, cap_out, chain_shift, byp_sel;

  collar_ir u_ir (
    .clk    (clk),
    .rst_n  (rst_n),
    .ser_in (wsi),
    .shf_en (ir_shift),
    .commit (ir_update),
    .ser_out(ir_so),
    .mode   (mode_q)
  );

  always_comb begin
    byp_sel     = (mode_q == MODE_BYP);
    cap_in      = capture_en && (mode_q == MODE_EXT);
    cap_out     = capture_en && (mode_q == MODE_INT);
    chain_shift = shift_en && !byp_sel;
  end

  collar_byp u_byp (
    .clk    (clk),
    .rst_n  (rst_n),
    .ser_in (wsi),
    .shf_en (shift_en && byp_sel),
    .cap_en (capture_en && byp_sel),
    .ser_out(byp_so)
  );

  for (genvar j = 0; j < N_CELL; j++) begin : g_cell
    logic par_bit, ser_bit, cap_bit;
    if (j < N_IN) begin : g_in
      assign par_bit = host_in[j];
      assign cap_bit = cap_in;
    end else begin : g_out
      assign par_bit = core_out[j-N_IN];
      assign cap_bit = cap_out;
    end
    if (j == 0) begin : g_head
      assign ser_bit = wsi;
    end else begin : g_link
      assign ser_bit = scan_q[j-1];
    end
    collar_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_en  (cap_bit),
      .shf_en  (chain_shift),
      .upd_en  (update_en),
      .par_in  (par_bit),
      .ser_in  (ser_bit),
      .ser_out (scan_q[j]),
      .hold_out(hold_q[j])
    );
  end

  always_comb begin
    core_in  = (mode_q == MODE_INT) ? hold_q[N_IN-1:0]      : host_in;
    host_out = (mode_q == MODE_EXT) ? hold_q[N_CELL-1:N_IN] : core_out;
    if (ir_shift)     wso = ir_so;
    else if (byp_sel) wso = byp_so;
    else              wso = scan_q[N_CELL-1];
  end
endmodule

// File: rtl/core_collar_chk.sv
`timescale 1ns/1ps
module core_collar_chk #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode,
  input logic [N_IN-1:0]  host_in,
  input logic [N_IN-1:0]  core_in,
  input logic [N_OUT-1:0] core_out,
  input logic [N_OUT-1:0] host_out,
  input logic             wsi,
  input logic             wso,
  input logic             capture_en,
  input logic             shift_en,
  input logic             update_en,
  input logic             ir_shift,
  input logic             ir_update
);
  // R1: reset holds functional mode
  always @(negedge clk) begin
    if (rst_n === 1'b0) begin
      p_reset_func_r1: assert (mode == 2'b00);
    end
  end

  p_func_path_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |-> (core_in == host_in && host_out == core_out));

  p_mode_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_update |=> (mode == $past(mode)));

  p_int_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && !update_en && !ir_update) |=> $stable(core_in));

  p_ext_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && !update_en && !ir_update) |=> $stable(host_out));

  p_byp_delay_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11 && shift_en && !capture_en && !ir_shift && !ir_update)
      |=> (ir_shift || wso == $past(wsi)));
endmodule

bind core_collar core_collar_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode      (mode_q),
  .host_in   (host_in),
  .core_in   (core_in),
  .core_out  (core_out),
  .host_out  (host_out),
  .wsi       (wsi),
  .wso       (wso),
  .capture_en(capture_en),
  .shift_en  (shift_en),
  .update_en (update_en),
  .ir_shift  (ir_shift),
  .ir_update (ir_update)
);

// File: tb/sim_core_collar.sv
`timescale 1ns/1ps
module sim_core_collar;
  localparam int NI = 4;
  localparam int NO = 3;
  localparam int NC = NI + NO;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NI-1:0] host_in;
  logic [NI-1:0] core_in;
  logic [NO-1:0] core_out;
  logic [NO-1:0] host_out;
  logic          wsi, wso;
  logic          capture_en, shift_en, update_en, ir_shift, ir_update;

  int n_run  = 0;
  int n_fail = 0;
  bit    q_exp[$];
  string q_tag[$];
  logic  obs_on = 1'b0;
  logic [NC-1:0] chain_m;
  logic [1:0]    ir_prev;

  always #5 clk = ~clk;

  core_collar #(.N_IN(NI), .N_OUT(NO)) u0 (
    .clk(clk), .rst_n(rst_n), .host_in(host_in), .core_in(core_in),
    .core_out(core_out), .host_out(host_out), .wsi(wsi), .wso(wso),
    .capture_en(capture_en), .shift_en(shift_en), .update_en(update_en),
    .ir_shift(ir_shift), .ir_update(ir_update)
  );

  // Monitor: pops one expected serial bit per observed cycle
  always @(negedge clk) begin
    if (obs_on) begin
      n_run++;
      if (q_exp.size() == 0) begin
        n_fail++;
        $display("FAIL scoreboard empty actual=%b expected=none", wso);
      end else begin
        bit    e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        if (wso !== e) begin
          n_fail++;
          $display("FAIL %s wso actual=%b expected=%b", t, wso, e);
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic look();
    @(negedge clk);
  endtask

  task automatic ir_shift_in(input logic [1:0] code);
    obs_on = 1'b1; ir_shift = 1'b1;
    for (int k = 0; k < 2; k++) begin
      wsi = code[k];
      q_exp.push_back(ir_prev[k]); q_tag.push_back("R3");
      tick();
    end
    obs_on = 1'b0; ir_shift = 1'b0;
    ir_prev = code;
  endtask

  task automatic ir_commit();
    ir_update = 1'b1; tick(); ir_update = 1'b0;
  endtask

  task automatic scan(input logic [NC-1:0] v, input string tag);
    obs_on = 1'b1; shift_en = 1'b1;
    for (int k = 0; k < NC; k++) begin
      wsi = v[NC-1-k];
      q_exp.push_back(chain_m[NC-1-k]); q_tag.push_back(tag);
      tick();
    end
    obs_on = 1'b0; shift_en = 1'b0;
    chain_m = v;
  endtask

  task automatic pulse_update();
    update_en = 1'b1; tick(); update_en = 1'b0;
  endtask

  task automatic pulse_capture();
    capture_en = 1'b1; tick(); capture_en = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; host_in = 4'hA; core_out = 3'h5; wsi = 1'b0;
    capture_en = 0; shift_en = 0; update_en = 0; ir_shift = 0; ir_update = 0;
    chain_m = '0; ir_prev = 2'b00;
    repeat (3) tick();
    look();
    chk(core_in, 4'hA, "R1 core_in in reset");
    chk(host_out, 3'h5, "R1 host_out in reset");
    rst_n = 1'b1; tick();

    // R2 functional pass-through, chain shifting does not disturb it
    host_in = 4'h3; core_out = 3'h6; look();
    chk(core_in, 4'h3, "R2 core_in");
    chk(host_out, 3'h6, "R2 host_out");
    tick();
    scan(7'b1011001, "R4");
    look();
    chk(core_in, 4'h3, "R2 after shift");
    chk(host_out, 3'h6, "R2 after shift");
    tick();

    // R3 instruction shifted but not committed
    ir_shift_in(2'b01);
    host_in = 4'hC; look();
    chk(core_in, 4'hC, "R3 before commit");
    chk(host_out, 3'h6, "R3 before commit");
    tick();
    ir_commit();

    // External test
    look();
    chk(host_out, 3'b000, "R6 reset hold values");
    tick();
    scan(7'b1010110, "R4");
    pulse_update();
    look();
    chk(host_out, 3'b101, "R6 driven from hold");
    chk(core_in, 4'hC, "R6 core_in follows host");
    tick();
    scan(7'b0101111, "R4");
    look();
    chk(host_out, 3'b101, "R9 stable while shifting");
    tick();
    host_in = 4'b1001;
    pulse_capture();
    chain_m[NI-1:0] = 4'b1001;
    scan(7'b0000000, "R5");

    // R11 capture beats shift
    host_in = 4'b0110;
    capture_en = 1'b1; shift_en = 1'b1; wsi = 1'b1; tick();
    capture_en = 1'b0; shift_en = 1'b0;
    chain_m = 7'b0000110;
    scan(7'b1100011, "R11");
    // R11 update with shift takes pre-shift contents
    shift_en = 1'b1; update_en = 1'b1; wsi = 1'b0; tick();
    shift_en = 1'b0; update_en = 1'b0;
    chain_m = 7'b1000110;
    look();
    chk(host_out, 3'b110, "R11 update during shift");
    tick();

    // Internal test
    ir_shift_in(2'b10);
    ir_commit();
    core_out = 3'b011; look();
    chk(core_in, 4'b0011, "R7 core_in from hold");
    chk(host_out, 3'b011, "R7 host_out follows core");
    tick();
    scan(7'b0001010, "R4");
    look();
    chk(core_in, 4'b0011, "R9 stable while shifting");
    tick();
    pulse_update();
    look();
    chk(core_in, 4'b1010, "R7 new hold value");
    tick();
    core_out = 3'b110;
    pulse_capture();
    chain_m[NC-1:NI] = 3'b110;
    scan(7'b0000000, "R8");

    // Bypass
    ir_shift_in(2'b11);
    ir_commit();
    host_in = 4'h9; core_out = 3'b010; look();
    chk(core_in, 4'h9, "R10 core_in pass-through");
    chk(host_out, 3'b010, "R10 host_out pass-through");
    tick();
    wsi = 1'b1; pulse_capture();
    begin
      logic [3:0] bits;
      logic       prev;
      bits = 4'b1101; prev = 1'b0;
      obs_on = 1'b1; shift_en = 1'b1;
      for (int k = 0; k < 4; k++) begin
        wsi = bits[k];
        q_exp.push_back(prev); q_tag.push_back("R10");
        prev = bits[k];
        tick();
      end
      obs_on = 1'b0; shift_en = 1'b0;
    end
    // chain untouched in bypass: back to internal test and read it
    ir_shift_in(2'b10);
    ir_commit();
    scan(7'b0000000, "R10 chain held");

    // R1 reset in the middle of internal test
    host_in = 4'h5; pulse_update();
    scan(7'b0001111, "R4");
    pulse_update();
    look();
    chk(core_in, 4'hF, "R7 before reset");
    tick();
    rst_n = 1'b0; tick();
    look();
    chk(core_in, 4'h5, "R1 core_in after reset");
    chk(host_out, 3'b010, "R1 host_out after reset");
    rst_n = 1'b1; tick();
    chain_m = '0;
    scan(7'b0000000, "R1 chain cleared");

    repeat (2) tick();
    if (q_exp.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", q_exp.size());
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule